// File: doc/BRIEF.md
# SMI Feature Negotiation Controller

This block turns writes to the power-management control port into system management interrupt requests, and runs a one-shot feature handshake with firmware that decides how those requests are delivered. Firmware writes a 64-bit feature request one byte at a time, least significant byte at the lowest address. It then writes the commit trigger. The block compares the request against a fixed host capability mask that is set by a parameter. A request that stays within the host mask is latched as the negotiated set, and the done flag is raised. Once the done flag is set, the negotiated set cannot change until reset.

A write to the control port with any code other than the two ACPI mode codes raises an SMI, but only when the APM-control enable bit of the SMI enable register is set. If the broadcast feature (feature bit 0) was negotiated, every CPU receives the SMI. Otherwise only the CPU that made the write receives it. A lock bit in the power-management control byte freezes itself and bit 0 of the SMI enable register until reset.

Top module: `smi_negotiator`

## Requirements
- R1: After reset, all outputs are zero: requested set, negotiated set, done flag, SMI enable, lock, SMI lines and ACPI pulses.
- R2: A write of byte D to address k (0..7) places D in bits 8k+7..8k of the requested set. The other bytes keep their values.
- R3: A write to the trigger (address 8) while the done flag is 0, with a request that is a subset of the host mask, copies the request into the negotiated set and sets the done flag. Both are visible on the cycle after the write.
- R4: A trigger write with a request that has any bit outside the host mask leaves the done flag at 0 and the negotiated set at 0.
- R5: Once the done flag is 1, further trigger writes change neither the done flag nor the negotiated set, whatever the request holds.
- R6: A control-port write (address 9) of 0xE1 gives a one-cycle ACPI-enable pulse, and a write of 0x1E gives a one-cycle ACPI-disable pulse. Neither code raises any SMI line.
- R7: A control-port write of any other value raises an SMI only when bit 5 of the SMI enable register (address 10) is set.
- R8: With feature bit 0 negotiated, an SMI goes to all CPUs. Without it, the SMI goes only to the CPU whose 2-bit ID came with the write.
- R9: Writing a 1 to bit 4 of the power-management control byte (address 11) sets the lock. While the lock is set, the lock cannot be cleared and bit 0 of the SMI enable register keeps its value. Bits 7..1 of the SMI enable register stay writable.
- R10: SMI lines and ACPI pulses are high for exactly one cycle per write. They become visible on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data byte |
| wr_cpu | input | 2 | ID of the CPU making the write |
| req_features | output | 64 | Requested feature set |
| neg_features | output | 64 | Negotiated feature set |
| feat_done | output | 1 | Negotiation accepted flag |
| smi_enable | output | 8 | SMI enable register |
| smi_lock | output | 1 | SMI configuration lock |
| smi_req | output | 4 | One SMI pulse line per CPU |
| acpi_on_pulse | output | 1 | ACPI-enable pulse |
| acpi_off_pulse | output | 1 | ACPI-disable pulse |

## Verification
The bench walks a single set bit across the high feature positions and commits each one. A subset check that masked the wrong width, or one that latched on rejection, would set the done flag or leak bits into the negotiated set. After a broadcast request has been accepted, the bench changes the request and commits again, and SMI delivery must keep broadcasting. A design that did not lock after acceptance would fall back to delivering to one CPU. The bench also checks that the two ACPI codes raise no SMI even with the enable bit set, and that enable bit 0 survives writes once the lock is set. A missing early exit or a wrong write mask would show up as stray SMI pulses or a cleared bit.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int FEAT_W = 64;
  localparam int ADDR_W = 4;
  typedef logic [FEAT_W-1:0] feat_t;

  localparam logic [ADDR_W-1:0] A_TRIGGER = 4'd8;
  localparam logic [ADDR_W-1:0] A_APMCTL  = 4'd9;
  localparam logic [ADDR_W-1:0] A_SMIEN   = 4'd10;
  localparam logic [ADDR_W-1:0] A_PMCTL   = 4'd11;

  localparam logic [7:0] CODE_ACPI_ON  = 8'hE1;
  localparam logic [7:0] CODE_ACPI_OFF = 8'h1E;
  localparam int APMC_BIT      = 5;
  localparam int LOCK_BIT      = 4;
  localparam int BROADCAST_BIT = 0;

  // a request is acceptable when it asks for nothing the host lacks
  function automatic logic within_host(feat_t req, feat_t host);
    return (req & ~host) == '0;
  endfunction

  // delivery mask: everyone on broadcast, else the writer only
  function automatic logic [3:0] smi_targets(logic bcast, logic [1:0] cpu, int n);
    logic [3:0] m;
    m = '0;
    for (int i = 0; i < 4; i++)
      if (i < n && (bcast || cpu == i[1:0])) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/smi_feat_regs.sv
module smi_feat_regs
  import smi_neg_pkg::*;
#(
  parameter feat_t HOST_FEATURES = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output feat_t             req_q,
  output feat_t             neg_q,
  output logic              done_q
);
  localparam int NBYTES = FEAT_W / 8;

  logic trig_evt, trig_accept, trig_reject;
  assign trig_evt    = wr_en && wr_addr == A_TRIGGER && !done_q;
  assign trig_accept = trig_evt && within_host(req_q, HOST_FEATURES);
  assign trig_reject = trig_evt && !within_host(req_q, HOST_FEATURES);

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[8*k +: 8] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(k)) req_q[8*k +: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= '0;
      done_q <= 1'b0;
    end else if (trig_accept) begin
      neg_q  <= req_q;
      done_q <= 1'b1;
    end
  end

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  assert_neg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(neg_q));
  assert_neg_in_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_q & ~HOST_FEATURES) == '0);
  assert_reject_no_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_reject |=> !done_q && neg_q == '0);
  assert_accept_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_accept |=> done_q && neg_q == $past(req_q));
endmodule

// File: rtl/smi_en_ctrl.sv
module smi_en_ctrl
  import smi_neg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        en_q,
  output logic              lock_q
);
  logic en_wr, pm_wr;
  logic [7:0] en_wmask;
  assign en_wr    = wr_en && wr_addr == A_SMIEN;
  assign pm_wr    = wr_en && wr_addr == A_PMCTL;
  assign en_wmask = lock_q ? 8'hFE : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= (wr_data & en_wmask) | (en_q & ~en_wmask);
      if (pm_wr && wr_data[LOCK_BIT]) lock_q <= 1'b1;
    end
  end

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_bit0_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(en_q[0]));
endmodule

// File: rtl/smi_apm_gen.sv
module smi_apm_gen
  import smi_neg_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        wr_cpu,
  input  logic              apmc_en,
  input  logic              bcast,
  output logic [3:0]        smi_q,
  output logic              on_q,
  output logic              off_q
);
  logic apm_wr, is_on, is_off, smi_evt;
  assign apm_wr  = wr_en && wr_addr == A_APMCTL;
  assign is_on   = apm_wr && wr_data == CODE_ACPI_ON;
  assign is_off  = apm_wr && wr_data == CODE_ACPI_OFF;
  assign smi_evt = apm_wr && !is_on && !is_off && apmc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q <= '0;
      on_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      smi_q <= smi_evt ? smi_targets(bcast, wr_cpu, NUM_CPUS) : 4'b0;
      on_q  <= is_on;
      off_q <= is_off;
    end
  end

  assert_acpi_no_smi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q || off_q) |-> smi_q == '0);
  assert_unicast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smi_evt && !bcast |=> $onehot0(smi_q));
  assert_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !apmc_en) |=> smi_q == '0);
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
  import smi_neg_pkg::*;
#(
  parameter int    NUM_CPUS      = 4,
  parameter feat_t HOST_FEATURES = 64'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  wr_cpu,
  output logic [63:0] req_features,
  output logic [63:0] neg_features,
  output logic        feat_done,
  output logic [7:0]  smi_enable,
  output logic        smi_lock,
  output logic [3:0]  smi_req,
  output logic        acpi_on_pulse,
  output logic        acpi_off_pulse
);
  smi_feat_regs #(.HOST_FEATURES(HOST_FEATURES)) u_feat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req_q(req_features), .neg_q(neg_features),
    .done_q(feat_done));

  smi_en_ctrl u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_q(smi_enable), .lock_q(smi_lock));

  smi_apm_gen #(.NUM_CPUS(NUM_CPUS)) u_apm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_cpu(wr_cpu), .apmc_en(smi_enable[APMC_BIT]),
    .bcast(neg_features[BROADCAST_BIT]), .smi_q(smi_req),
    .on_q(acpi_on_pulse), .off_q(acpi_off_pulse));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> smi_req == '0 && !acpi_on_pulse && !acpi_off_pulse);
endmodule

// File: tb/tb_smi_negotiator.sv
module tb_smi_negotiator;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] wr_cpu = 0;
  logic [63:0] req_features, neg_features;
  logic feat_done, smi_lock, acpi_on_pulse, acpi_off_pulse;
  logic [7:0] smi_enable;
  logic [3:0] smi_req;
  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  smi_negotiator dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, logic [1:0] c = 0);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d; wr_cpu = c;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic put_req(logic [63:0] v);
    for (int k = 0; k < 8; k++) wr(4'(k), v[8*k +: 8]);
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic check_zero(string tag);
    chk({tag, " req"}, req_features, 0);
    chk({tag, " neg"}, neg_features, 0);
    chk({tag, " done"}, 64'(feat_done), 0);
    chk({tag, " en"}, 64'(smi_enable), 0);
    chk({tag, " lock"}, 64'(smi_lock), 0);
    chk({tag, " smi"}, 64'(smi_req), 0);
    chk({tag, " acpi"}, 64'({acpi_on_pulse, acpi_off_pulse}), 0);
  endtask

  initial begin
    logic [63:0] pat;
    do_reset();
    check_zero("R1");

    // R2: byte lanes, little endian
    pat = 0;
    for (int k = 0; k < 8; k++) pat[8*k +: 8] = 8'(8'h11 * (k + 1));
    put_req(pat);
    chk("R2 bytes", req_features, pat);
    wr(4'd3, 8'hA5);
    pat[31:24] = 8'hA5;
    chk("R2 single lane", req_features, pat);

    // R4: single out-of-mask bits walked across the word
    for (int b = 1; b < 64; b += 5) begin
      put_req(64'd1 << b);
      wr(4'd8, 8'h00);
      chk("R4 done stays 0", 64'(feat_done), 0);
      chk("R4 neg stays 0", neg_features, 0);
    end
    put_req(64'h8000_0000_0000_0001);
    wr(4'd8, 8'h01);
    chk("R4 mixed rejected", 64'(feat_done), 0);

    // R7: gating by APMC bit
    wr(4'd9, 8'h55, 2'd1);
    chk("R7 disabled no smi", 64'(smi_req), 0);
    wr(4'd10, 8'h20);
    chk("R7 enable reg", 64'(smi_enable), 64'h20);
    // R8 unicast, R10 single cycle
    for (int c = 0; c < 4; c++) begin
      wr(4'd9, 8'(8'h40 + c), 2'(c));
      chk("R8 unicast", 64'(smi_req), 64'(1 << c));
      @(negedge clk);
      chk("R10 pulse ends", 64'(smi_req), 0);
    end
    // R6 ACPI codes
    wr(4'd9, 8'hE1, 2'd2);
    chk("R6 on pulse", 64'({acpi_on_pulse, acpi_off_pulse}), 64'b10);
    chk("R6 on no smi", 64'(smi_req), 0);
    @(negedge clk);
    chk("R10 acpi ends", 64'(acpi_on_pulse), 0);
    wr(4'd9, 8'h1E, 2'd2);
    chk("R6 off pulse", 64'({acpi_on_pulse, acpi_off_pulse}), 64'b01);
    chk("R6 off no smi", 64'(smi_req), 0);

    // R3 accept broadcast
    put_req(64'h1);
    wr(4'd8, 8'h00);
    chk("R3 done", 64'(feat_done), 1);
    chk("R3 neg", neg_features, 64'h1);
    // R5 locked after accept
    put_req(64'h0);
    wr(4'd8, 8'h00);
    chk("R5 neg kept", neg_features, 64'h1);
    chk("R5 done kept", 64'(feat_done), 1);
    // R8 broadcast
    wr(4'd9, 8'h77, 2'd2);
    chk("R8 broadcast", 64'(smi_req), 64'hF);

    // R9 lock
    wr(4'd10, 8'h21);
    wr(4'd11, 8'h10);
    chk("R9 lock set", 64'(smi_lock), 1);
    wr(4'd10, 8'h20);
    chk("R9 bit0 held", 64'(smi_enable), 64'h21);
    wr(4'd10, 8'h00);
    chk("R9 upper writable", 64'(smi_enable), 64'h01);
    wr(4'd11, 8'h00);
    chk("R9 lock held", 64'(smi_lock), 1);
    wr(4'd9, 8'h33, 2'd0);
    chk("R7 cleared no smi", 64'(smi_req), 0);

    do_reset();
    check_zero("R1 second reset");
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule